// File: doc/BRIEF.md
# Inline SPI Frame CRC Checker

This block sits beside an SPI link and checks every transfer on it. It does not drive the link. It samples the raw serial clock, the data line and the active-low chip select through a synchroniser inside the block. While a frame is open, it folds each payload bit into a 16-bit CRC as the bit passes on the wire. No fetch or sequencing logic feeds the CRC. The sender appends its own CRC to the payload in the same transfer, and the block captures that field from the wire as well.

When chip select returns high, the block makes one of two decisions. If the number of clocked bits is wrong, it flags a length fault. Otherwise it compares the computed CRC with the captured one and flags a CRC fault if they differ. Either fault raises a latched trip output that takes the system to a safe state. The trip stays set until a clear pulse arrives.

The check runs on every transfer, so each frame also exercises the checker itself.

Top module: `spi_crc_checker`

## Requirements
- R1: After reset, trip, fault_crc and fault_len are all 0.
- R2: A frame has 16 payload bits followed by 16 CRC bits, sent MSB first and sampled on rising spi_sclk while spi_cs_n is low. The CRC uses polynomial 0x1021, starts at 0xFFFF, and has no final inversion. A frame whose CRC field matches the payload leaves trip at 0.
- R3: A frame of 32 bits whose CRC field differs from the payload CRC sets trip and fault_crc, and leaves fault_len at 0. Trip is set on the third rising clk edge after spi_cs_n is first driven high.
- R4: A frame whose bit count is not 32 when spi_cs_n rises sets trip and fault_len, and leaves fault_crc at 0.
- R5: Once set, trip and the fault flags stay set until trip_clr is sampled high.
- R6: If trip_clr is high in the same cycle that a new fault is detected, trip and that fault flag remain set.
- R7: The CRC and the bit count restart on each falling edge of spi_cs_n, so a correct frame that follows a faulty one leaves trip at 0.
- R8: spi_sclk edges while spi_cs_n is high are ignored and do not disturb the next frame.
- R9: A trip_clr pulse with no fault being detected in that cycle returns trip, fault_crc and fault_len to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Raw serial clock from the link |
| spi_data | input | 1 | Raw serial data line being checked |
| spi_cs_n | input | 1 | Raw active-low chip select that delimits a frame |
| trip_clr | input | 1 | Clear pulse for the latched trip and fault flags |
| trip | output | 1 | Latched safe-state request |
| fault_crc | output | 1 | Latched flag: CRC mismatch seen |
| fault_len | output | 1 | Latched flag: wrong bit count seen |

## Verification
The assertions assume the link runs much slower than clk. Each spi_sclk phase must last at least two clk cycles so that every edge survives the synchroniser. The data line must be stable around each rising spi_sclk. Chip select must only change while spi_sclk is low, and well clear of any spi_sclk edge. The stimulus holds each serial clock phase for four clk cycles and sets data while spi_sclk is low. It also waits several cycles before and after every chip-select transition, so those timing assumptions hold for every frame.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

    localparam int CRC_W = 16;

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        logic crc_bad;
        logic len_bad;
    } fault_t;

    // One serial CRC update, most significant bit first.
    function automatic crc_t crc_step(crc_t cur, logic bit_in, crc_t poly);
        logic fb;
        fb = cur[CRC_W-1] ^ bit_in;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    logic [W-1:0] pipe [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout  = pipe[STAGES-1];
    assign dprev = pipe[STAGES];
endmodule

// File: rtl/crc_frame_engine.sv
module crc_frame_engine
    import spi_crc_pkg::*;
#(
    parameter int   PAYLOAD_BITS = 16,
    parameter crc_t POLY         = 16'h1021,
    parameter crc_t SEED         = 16'hFFFF,
    localparam int  TOTAL_BITS   = PAYLOAD_BITS + CRC_W,
    localparam int  CNT_W        = $clog2(TOTAL_BITS + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             bit_valid,
    input  logic             bit_in,
    output crc_t             crc_calc,
    output crc_t             crc_rx,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TOTAL_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(PAYLOAD_BITS);

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            crc_calc <= SEED;
            crc_rx   <= '0;
            bit_cnt  <= '0;
        end else if (bit_valid) begin
            if (bit_cnt < CNT_DATA)
                crc_calc <= crc_step(crc_calc, bit_in, POLY);
            else
                crc_rx <= {crc_rx[CRC_W-2:0], bit_in};
            if (bit_cnt != CNT_SAT)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_crc_checker.sv
module spi_crc_checker
    import spi_crc_pkg::*;
#(
    parameter int   PAYLOAD_BITS = 16,
    parameter crc_t POLY         = 16'h1021,
    parameter crc_t SEED         = 16'hFFFF,
    parameter int   SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_data,
    input  logic spi_cs_n,
    input  logic trip_clr,
    output logic trip,
    output logic fault_crc,
    output logic fault_len
);
    localparam int TOTAL_BITS = PAYLOAD_BITS + CRC_W;
    localparam int CNT_W      = $clog2(TOTAL_BITS + 2);

    // Bit order in the synchronised vector: {cs_n, sclk, data}
    logic [2:0] line_now, line_old;

    line_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst),
        .din({spi_cs_n, spi_sclk, spi_data}),
        .dout(line_now), .dprev(line_old)
    );

    logic cs_fall, frame_end, sclk_rise, bit_valid;
    assign cs_fall   = !line_now[2] &&  line_old[2];
    assign frame_end =  line_now[2] && !line_old[2];
    assign sclk_rise =  line_now[1] && !line_old[1];
    assign bit_valid =  sclk_rise && !line_now[2];

    crc_t             crc_calc, crc_rx;
    logic [CNT_W-1:0] bit_cnt;

    crc_frame_engine #(.PAYLOAD_BITS(PAYLOAD_BITS), .POLY(POLY), .SEED(SEED)) u_engine (
        .clk(clk), .rst(rst),
        .frame_start(cs_fall), .bit_valid(bit_valid), .bit_in(line_now[0]),
        .crc_calc(crc_calc), .crc_rx(crc_rx), .bit_cnt(bit_cnt)
    );

    fault_t new_fault, held;

    always_comb begin
        new_fault         = '0;
        new_fault.len_bad = frame_end && (bit_cnt != CNT_W'(TOTAL_BITS));
        new_fault.crc_bad = frame_end && (bit_cnt == CNT_W'(TOTAL_BITS))
                            && (crc_calc != crc_rx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            trip <= 1'b0;
        end else begin
            held <= (trip_clr ? fault_t'('0) : held) | new_fault;
            trip <= (trip && !trip_clr) || (new_fault != '0);
        end
    end

    assign fault_crc = held.crc_bad;
    assign fault_len = held.len_bad;
endmodule

module spi_crc_guard (
    input logic clk,
    input logic rst,
    input logic trip_clr,
    input logic trip,
    input logic fault_crc,
    input logic fault_len,
    input logic frame_end
);
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!trip && !fault_crc && !fault_len));

    p_fault_means_trip_r3: assert property (@(posedge clk) disable iff (rst)
        (fault_crc || fault_len) |-> trip);

    p_trip_from_frame_end_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(trip) |-> $past(frame_end));

    p_trip_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (trip && !trip_clr) |=> trip);

    p_clear_works_r9: assert property (@(posedge clk) disable iff (rst)
        (trip_clr && !frame_end) |=> (!trip && !fault_crc && !fault_len));
endmodule

bind spi_crc_checker spi_crc_guard u_guard (
    .clk(clk), .rst(rst), .trip_clr(trip_clr), .trip(trip),
    .fault_crc(fault_crc), .fault_len(fault_len), .frame_end(frame_end)
);

// File: tb/spi_crc_checker_test.sv
module spi_crc_checker_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdata = 1'b0, cs_n = 1'b1, clr = 1'b0;
    logic trip, f_crc, f_len;
    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    spi_crc_checker uut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_data(sdata),
        .spi_cs_n(cs_n), .trip_clr(clr),
        .trip(trip), .fault_crc(f_crc), .fault_len(f_len)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] d);
        logic [15:0] c;
        c = 16'hFFFF ^ d;
        for (int k = 0; k < 16; k++)
            c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        return c;
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: {trip,fault_crc,fault_len} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Opens a frame and clocks n bits (MSB of the n-bit field first); cs_n left low.
    task automatic frame_body(input logic [47:0] bits, input int n);
        @(negedge clk) cs_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = bits[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
    endtask

    task automatic send_frame(input logic [47:0] bits, input int n);
        frame_body(bits, n);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [15:0] pay, good;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        chk("R1 reset state", {trip, f_crc, f_len}, 3'b000);

        // Sweep of payloads; each good frame follows a faulted and cleared one (R7).
        for (int i = 0; i < 40; i++) begin
            pay  = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(i * 16'h0631) ^ 16'(i << 9);
            good = ref_crc(pay);
            send_frame({16'h0, pay, good}, 32);
            chk(i == 0 ? "R2 good frame" : "R7 good frame after faulted one",
                {trip, f_crc, f_len}, 3'b000);
            send_frame({16'h0, pay, good ^ (16'h1 << (i % 16))}, 32);
            chk("R3 crc mismatch", {trip, f_crc, f_len}, 3'b110);
            wait_clk(20);
            chk("R5 trip held", {trip, f_crc, f_len}, 3'b110);
            pulse_clr();
            chk("R9 clear", {trip, f_crc, f_len}, 3'b000);
        end

        // Wrong lengths, with otherwise plausible content.
        pay = 16'hA5C3;
        send_frame({16'h0, pay, ref_crc(pay)} >> 1, 31);
        chk("R4 short frame", {trip, f_crc, f_len}, 3'b101);
        pulse_clr();
        send_frame({15'h0, pay, ref_crc(pay), 1'b0}, 33);
        chk("R4 long frame", {trip, f_crc, f_len}, 3'b101);
        pulse_clr();
        send_frame(48'h0, 0);
        chk("R4 empty frame", {trip, f_crc, f_len}, 3'b101);
        pulse_clr();

        // R8: serial clock activity while deselected.
        for (int k = 0; k < 5; k++) begin
            sdata = k[0];
            wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
        end
        wait_clk(4);
        chk("R8 idle clocks ignored", {trip, f_crc, f_len}, 3'b000);
        send_frame({16'h0, pay, ref_crc(pay)}, 32);
        chk("R8 frame after idle clocks", {trip, f_crc, f_len}, 3'b000);

        // R6: clear lands on the cycle the fault is detected (third clk edge after cs_n high).
        frame_body({16'h0, pay, ref_crc(pay) ^ 16'h8000}, 32);
        cs_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        chk("R6 clear collides with new fault", {trip, f_crc, f_len}, 3'b110);
        pulse_clr();
        chk("R9 clear after collision", {trip, f_crc, f_len}, 3'b000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule